// File: doc/BRIEF.md
# Indirect Calibration Register Bridge

This block gives a host access to a private bank of 64 calibration words, 32 bits each, through four small host-side registers. The host first loads a control register with a direction bit and a 6-bit internal address. For a write it also loads a data register. It then raises a start bit. Each rising edge of that bit runs exactly one internal access, and the host lowers the bit again before the next one. The result of a read comes back in a read-data register, which the host reads through the same register port.

The bank is locked after reset, and writes to any location other than address 0x00 are dropped while it is locked. Writing the unlock key 0xA5000000 to address 0x00 opens the bank. Writing any other value there locks it again. Two locations have a fixed meaning. Address 0x26 holds a calibration code produced by hardware; it is read-only and resets to 0x13. Address 0x22 is the manual calibration control. Its bit 7 and its low 5 bits drive the manual-mode outputs toward the delay line that sits behind the bank.

Top module: `calp_bridge`

## Requirements
- R1: After reset every host register reads 0, `busy` is 0, `wp_locked` is 1, `manual_en` is 0 and `manual_code` is 0.
- R2: Host register select: 0 is the control register, 1 is write data, 2 is start (bit 0), and 3 is read data. `host_rdata` shows the selected register one clock after `host_sel` is applied. A host write to select 3 is ignored.
- R3: The control register keeps only bit 8 (1 = read, 0 = write) and bits 5:0 (the internal address). Every other bit written is dropped, so it reads back as 0 and has no effect on which location is accessed.
- R4: Each 0-to-1 transition of start bit 0 raises `busy` for exactly one cycle, starting on the second rising clock edge after the host write that set the bit. Holding the bit at 1 launches nothing further.
- R5: At the end of the `busy` cycle of a read, the read-data register takes the word at the addressed location. It does not change at any other time.
- R6: An unlocked write stores the write-data register at the addressed location. A later read of that location returns the stored word.
- R7: While the bank is locked, a write to any address other than 0x00 changes nothing, including the manual-mode outputs.
- R8: A write of 0xA5000000 to address 0x00 clears `wp_locked` at the end of its `busy` cycle. A write of any other value to 0x00 sets it. The value written is stored at 0x00 in either case.
- R9: Address 0x26 reads as the 5-bit calibration code, zero-extended, with reset value 0x13. Writes to 0x26 are ignored.
- R10: An accepted write to 0x22 sets `manual_en` from data bit 7 and `manual_code` from data bits 4:0. A read of 0x22 returns those bits in the same positions, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered readback of the selected host register |
| busy | output | 1 | High for the single cycle in which an internal access executes |
| wp_locked | output | 1 | Write protection of the bank is active |
| manual_en | output | 1 | Manual calibration mode enable |
| manual_code | output | 5 | Manual calibration code |

## Verification
The in-RTL assertions check on every cycle that `busy` never lasts longer than one cycle and that the read-data register moves only at the end of a `busy` cycle. They also check that the lock opens only through a key write to address 0x00, that it re-arms only through a write to 0x00, and that the manual control holds its value through writes rejected by the lock. The bench scenarios show what the assertions cannot: that the stored contents survive across many mixed accesses, that masked address bits really alias onto the low 6 bits, that a start bit held high launches no second access, and that the calibration-code location ignores writes.

// File: rtl/calp_pkg.sv
package calp_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned CODE_W    = 5;
  localparam int unsigned DIR_BIT   = 8;
  localparam int unsigned MEN_BIT   = 7;
  localparam logic [31:0] UNLOCK_KEY = 32'hA500_0000;
  localparam logic [5:0]  WP_ADDR    = 6'h00;
  localparam logic [5:0]  MCAL_ADDR  = 6'h22;
  localparam logic [5:0]  CODE_ADDR  = 6'h26;
  localparam logic [4:0]  CODE_RESET = 5'h13;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_START = 2'd2,
    SEL_RDATA = 2'd3
  } host_sel_e;
endpackage

// File: rtl/calp_host.sv
module calp_host
  import calp_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bank_rdata,
  output logic [DW-1:0] host_rdata,
  output logic          launch,
  output logic          l_rd,
  output logic [AW-1:0] l_addr,
  output logic [DW-1:0] l_wdata
);
  logic          start_q, start_d;
  logic [DW-1:0] mode_view;
  logic [DW-1:0] start_view;
  logic [DW-1:0] rd_mux;

  // Control, write-data and start registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      l_rd    <= 1'b0;
      l_addr  <= '0;
      l_wdata <= '0;
      start_q <= 1'b0;
    end else if (we) begin
      unique case (host_sel_e'(sel))
        SEL_MODE: begin
          l_rd   <= wdata[DIR_BIT];
          l_addr <= wdata[AW-1:0];
        end
        SEL_WDATA: l_wdata <= wdata;
        SEL_START: start_q <= wdata[0];
        default: ;
      endcase
    end
  end

  // Edge detector on the start bit: one launch per rising transition.
  always_ff @(posedge clk) begin
    if (rst) start_d <= 1'b0;
    else     start_d <= start_q;
  end
  assign launch = start_q & ~start_d;

  always_comb begin
    mode_view          = '0;
    mode_view[AW-1:0]  = l_addr;
    mode_view[DIR_BIT] = l_rd;
    start_view         = '0;
    start_view[0]      = start_q;
    unique case (host_sel_e'(sel))
      SEL_MODE:  rd_mux = mode_view;
      SEL_WDATA: rd_mux = l_wdata;
      SEL_START: rd_mux = start_view;
      default:   rd_mux = bank_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_mux;
  end
endmodule

// File: rtl/calp_bank.sv
module calp_bank
  import calp_pkg::*;
#(
  parameter int unsigned DW        = DATA_W,
  parameter int unsigned AW        = ADDR_W,
  parameter int unsigned CW        = CODE_W,
  parameter logic [CW-1:0] CAL_RST = CODE_RESET,
  parameter logic [DW-1:0] KEY     = UNLOCK_KEY
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          locked,
  output logic          man_en,
  output logic [CW-1:0] man_code
);
  localparam int unsigned DEPTH = 1 << AW;

  logic          op_rd;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic [CW-1:0] code_q;
  logic          wr_ok;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] mem [DEPTH];

  // Capture the access on launch; it executes during the busy cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op_rd    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else begin
      busy <= launch;
      if (launch) begin
        op_rd    <= l_rd;
        op_addr  <= l_addr;
        op_wdata <= l_wdata;
      end
    end
  end

  assign wr_ok = busy && !op_rd && (op_addr == WP_ADDR[AW-1:0] || !locked)
                 && op_addr != CODE_ADDR[AW-1:0];

  // Storage array, no reset so that it maps to RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[op_addr] <= op_wdata;
  end

  always_comb begin
    rd_word = '0;
    if (op_addr == CODE_ADDR[AW-1:0]) begin
      rd_word[CW-1:0] = code_q;
    end else if (op_addr == MCAL_ADDR[AW-1:0]) begin
      rd_word[CW-1:0]  = man_code;
      rd_word[MEN_BIT] = man_en;
    end else begin
      rd_word = mem[op_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      locked   <= 1'b1;
      man_en   <= 1'b0;
      man_code <= '0;
      code_q   <= CAL_RST;
    end else begin
      if (busy && op_rd) rdata <= rd_word;
      if (wr_ok && op_addr == WP_ADDR[AW-1:0]) locked <= (op_wdata != KEY);
      if (wr_ok && op_addr == MCAL_ADDR[AW-1:0]) begin
        man_en   <= op_wdata[MEN_BIT];
        man_code <= op_wdata[CW-1:0];
      end
    end
  end

  // R4
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rdata));
  // R7
  locked_mcal_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_rd && locked && op_addr == MCAL_ADDR[AW-1:0])
      |=> ($stable(man_en) && $stable(man_code)));
  // R8
  unlock_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(busy && !op_rd && op_addr == WP_ADDR[AW-1:0]
                            && op_wdata == KEY));
  // R8
  relock_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(busy && !op_rd && op_addr == WP_ADDR[AW-1:0]));
endmodule

// File: rtl/calp_bridge.sv
module calp_bridge
  import calp_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          busy,
  output logic          wp_locked,
  output logic          manual_en,
  output logic [CW-1:0] manual_code
);
  logic          launch, l_rd;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wdata, bank_rdata;

  calp_host #(.DW(DW), .AW(AW)) u_host (
    .clk(clk), .rst(rst), .we(host_we), .sel(host_sel), .wdata(host_wdata),
    .bank_rdata(bank_rdata), .host_rdata(host_rdata), .launch(launch),
    .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata)
  );

  calp_bank #(.DW(DW), .AW(AW), .CW(CW)) u_bank (
    .clk(clk), .rst(rst), .launch(launch), .l_rd(l_rd), .l_addr(l_addr),
    .l_wdata(l_wdata), .busy(busy), .rdata(bank_rdata), .locked(wp_locked),
    .man_en(manual_en), .man_code(manual_code)
  );
endmodule

// File: tb/calp_bridge_bench.sv
module calp_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy, wp_locked, manual_en;
  logic [4:0]  manual_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] mdl [64];
  bit          known [64];
  bit          m_lock;
  logic [7:0]  m_mcal;
  logic [31:0] m_rdata;

  always #4 clk = ~clk;

  calp_bridge u_calp_bridge (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .wp_locked(wp_locked), .manual_en(manual_en), .manual_code(manual_code)
  );

  function automatic logic [31:0] mode_view(input logic [31:0] v);
    return v & 32'h0000_013F;
  endfunction

  function automatic logic [7:0] mcal_fold(input logic [31:0] d);
    return {d[7], 2'b00, d[4:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    host_we = 1'b0; host_sel = sel;
    @(negedge clk);
    v = host_rdata;
  endtask

  // One complete access; busy timing checked against R4.
  task automatic access(input bit rd, input logic [31:0] mode_raw,
                        input logic [31:0] d, input bit chk_busy);
    logic [31:0] mode;
    logic [5:0]  a;
    mode = {mode_raw[31:9], rd, mode_raw[7:0]};
    a = mode[5:0];
    hw(2'd0, mode);
    if (!rd) hw(2'd1, d);
    hw(2'd2, 32'h1);
    if (chk_busy) chk("R4 busy before launch", {31'b0, busy}, 32'h0);
    @(negedge clk);
    if (chk_busy) chk("R4 busy in access cycle", {31'b0, busy}, 32'h1);
    @(negedge clk);
    if (chk_busy) chk("R4 busy after one cycle", {31'b0, busy}, 32'h0);
    // update model
    if (rd) begin
      if (a == 6'h26)       m_rdata = 32'h13;
      else if (a == 6'h22)  m_rdata = {24'b0, m_mcal};
      else if (known[a])    m_rdata = mdl[a];
      else                  m_rdata = 32'hxxxx_xxxx;
    end else if (a != 6'h26 && (a == 6'h00 || !m_lock)) begin
      mdl[a] = d; known[a] = 1'b1;
      if (a == 6'h00) m_lock = (d != 32'hA500_0000);
      if (a == 6'h22) m_mcal = mcal_fold(d);
    end
    hw(2'd2, 32'h0);
  endtask

  task automatic check_read(input string req);
    logic [31:0] v;
    hr(2'd3, v);
    if (!$isunknown(m_rdata)) chk(req, v, m_rdata);
  endtask

  task automatic check_side(input string req);
    chk({req, " lock"}, {31'b0, wp_locked}, {31'b0, m_lock});
    chk({req, " manual"}, {26'b0, manual_en, manual_code},
        {26'b0, m_mcal[7], m_mcal[4:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) known[i] = 1'b0;
    m_lock = 1'b1; m_mcal = 8'h00; m_rdata = 32'h0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      hr(s[1:0], v);
      chk("R1 host register reset", v, 32'h0);
    end
    chk("R1 busy reset", {31'b0, busy}, 32'h0);
    check_side("R1");

    // R2/R3 control register masking and readback
    hw(2'd0, 32'hFFFF_FEC5);
    hr(2'd0, v); chk("R3 control readback masked", v, mode_view(32'hFFFF_FEC5));
    hw(2'd1, 32'h1234_5678);
    hr(2'd1, v); chk("R2 write-data readback", v, 32'h1234_5678);
    hw(2'd3, 32'hDEAD_BEEF);
    hr(2'd3, v); chk("R2 write to read-data ignored", v, 32'h0);

    // R9 calibration code at reset, R5 read path
    access(1'b1, 32'h26, 32'h0, 1'b1);
    check_read("R9 calibration code reset value");

    // R7 locked writes ignored
    access(1'b0, 32'h22, 32'hFF, 1'b1);
    check_side("R7 locked write to 0x22");
    access(1'b1, 32'h22, 32'h0, 1'b0);
    check_read("R7 0x22 unchanged while locked");

    // R8 unlock with key
    access(1'b0, 32'h00, 32'hA500_0000, 1'b0);
    check_side("R8 unlock");
    // R10 manual control
    access(1'b0, 32'h22, 32'hFFFF_FFFF, 1'b0);
    check_side("R10 manual write");
    access(1'b1, 32'h22, 32'h0, 1'b0);
    check_read("R10 manual readback");
    // R9 write to code ignored
    access(1'b0, 32'h26, 32'h0000_0001, 1'b0);
    access(1'b1, 32'h26, 32'h0, 1'b0);
    check_read("R9 code ignores writes");
    // R6 store and R3 aliasing of high address bits
    access(1'b0, 32'hFFFF_FE3F, 32'hCAFE_F00D, 1'b0);
    access(1'b1, 32'h3F, 32'h0, 1'b0);
    check_read("R6 R3 aliased write lands at 0x3F");

    // R4 held start bit launches nothing more; R5 rdata stable
    hw(2'd0, 32'h100 | 32'h26);
    hw(2'd2, 32'h1);
    @(negedge clk);
    @(negedge clk);
    chk("R4 busy dropped", {31'b0, busy}, 32'h0);
    m_rdata = 32'h13;
    hw(2'd0, 32'h100 | 32'h3F);
    repeat (4) begin
      @(negedge clk);
      chk("R4 no relaunch while start held", {31'b0, busy}, 32'h0);
    end
    check_read("R5 rdata holds without access");
    hw(2'd2, 32'h0);

    // R8 relock with non-key value
    access(1'b0, 32'h00, 32'h0000_0055, 1'b0);
    check_side("R8 relock");
    access(1'b1, 32'h00, 32'h0, 1'b0);
    check_read("R8 address 0 stores value");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      bit rd;
      logic [31:0] mraw, d;
      rd = ($urandom % 2) == 0;
      mraw = $urandom;
      d = $urandom;
      case ($urandom % 8)
        0: begin mraw[5:0] = 6'h00; d = 32'hA500_0000; rd = 1'b0; end
        1: mraw[5:0] = 6'h22;
        2: mraw[5:0] = 6'h26;
        default: mraw[5:0] = 6'(($urandom % 8) + 8);
      endcase
      access(rd, mraw, d, (n % 16) == 0);
      if (rd) check_read("R6 random read");
      check_side("R7 R8 R10 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule